// File: doc/BRIEF.md
# Comparator Output Conditioner

This block is the digital back end of an analog comparator. It takes the raw, asynchronous comparator bit, brings it into the clock domain through a two-flop synchronizer, optionally inverts it, and passes it through a majority-free agreement filter. The filter lets a new level through only after a programmed number of consecutive samples disagree with the current output. Samples are taken either on a programmable clock interval or, in external-sample mode, on every cycle that a gating input is high.

The filtered level drives sticky rising and falling flags. These flags are set on edges, or by level while the chip is in stop mode if so configured. The flags can raise either an interrupt or a DMA request. A small 8-bit register port holds the control fields, the sample period and the flag/enable bits. The output pin is driven with either the filtered or the synchronized unfiltered level. The register port is plain: a write takes effect at the clock edge on which `reg_we_i` is high, and reads are combinational. There is no back-pressure.

Top module: `cmp_cond`

## Requirements
- R1: After reset every register reads 0, and `pin_o`, `irq_o` and `dma_o` are 0.
- R2: The raw input reaches the unfiltered level through two clock stages. With filter count 0 and external sampling off, `pin_o` follows a raw change on the second clock edge after it, not the first.
- R3: Control bit 3 (invert) inverts the synchronized level before it enters the filter and the pin path.
- R4: Control bits 7:5 hold a filter count N from 1 to 7. The filtered output changes only after N consecutive samples differ from it. With N=1 it changes on the first such sample. A shorter disagreeing burst is rejected.
- R5: With filter count 0 and control bit 4 (external sampling) clear, the filtered output equals the unfiltered level.
- R6: With filter count 0 and external sampling set, the filtered output is held at 0.
- R7: The period register (address 1) sets the number of clocks between samples. A value of 0 means one sample every clock.
- R8: With external sampling set, the filter samples only on cycles where `gate_i` is high, and holds its output otherwise.
- R9: Control bit 2 selects the pin source: the filtered level when 0, the unfiltered level when 1. Control bit 1 must be set for `pin_o` to be high.
- R10: Status bit 1 (rising flag) sets on a low-to-high change of the filtered output, and status bit 2 (falling flag) sets on a high-to-low change. Writing 1 to a flag bit clears it. A clear in the same cycle as a new set leaves the flag set.
- R11: While `stop_i` is high and status bit 5 is 0, the rising flag sets whenever the filtered output is high, and the falling flag sets whenever it is low. With status bit 5 set, the flags stay edge sensitive.
- R12: Status bit 3 enables the rising flag and status bit 4 enables the falling flag to request service. The request goes to `irq_o`, or to `dma_o` when status bit 6 is set, never to both.
- R13: With control bit 0 (enable) clear, `pin_o`, `irq_o` and `dma_o` are 0.
- R14: A write that changes the filter count or the period discards the agreement count gathered so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_raw_i | input | 1 | Raw comparator bit, asynchronous |
| gate_i | input | 1 | Sample strobe used in external-sample mode |
| stop_i | input | 1 | Chip is in stop mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 period, 2 status |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational; status bit 0 is the filtered level |
| pin_o | output | 1 | Conditioned comparator output pin |
| irq_o | output | 1 | Interrupt request |
| dma_o | output | 1 | DMA request |

## Verification
The unfiltered level is due two edges after a raw change. A filtered change with period 0 is due on edge 2+N. A flag, and the request it drives, is due one edge after the filtered change. The bench therefore drives inputs at a falling edge, counts rising edges exactly, and samples at the next falling edge. Each filter check is paired with a check one edge early that must still see the old level. For a nonzero period the phase of the sample counter is unknown, so those checks use the earliest and latest due edges: no change by edge 2+(N-1)P+... and a change by edge 2+N·P. Register writes land on the edge that carries the strobe, so the bench times coincident clear-and-set and restart cases against that edge.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_PER  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_STAT = 2'd2;

  localparam int ST_COUT  = 0;
  localparam int ST_RISE  = 1;
  localparam int ST_FALL  = 2;
  localparam int ST_CFG_LO = 3;
  localparam int ST_CFG_HI = 6;

  typedef struct packed {
    logic [2:0] cnt;
    logic       ext;
    logic       inv;
    logic       raw_sel;
    logic       pin_en;
    logic       en;
  } ctrl_t;

  typedef struct packed {
    logic dma_en;
    logic stop_edge;
    logic fall_ie;
    logic rise_ie;
  } irqcfg_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [3:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  age_q <= '0;
    else if (age_q < 4'(STAGES)) age_q <= age_q + 4'd1;
  end

  // R2: output is the input delayed by exactly STAGES edges
  a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 4'(STAGES)) |-> (q_o == $past(d_i, STAGES)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             ext_i,
  input  logic             gate_i,
  input  logic [PER_W-1:0] per_i,
  output logic             tick_o
);
  logic [PER_W-1:0] ctr_q;
  logic per_tick;

  assign per_tick = (per_i == '0) || (ctr_q == per_i - PER_W'(1));
  assign tick_o   = run_i && (ext_i ? gate_i : per_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                       ctr_q <= '0;
    else if (!run_i || restart_i || ext_i || per_tick) ctr_q <= '0;
    else                                              ctr_q <= ctr_q + PER_W'(1);
  end

  // R7: with a period above one, two internal ticks are never adjacent
  a_r7_period_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && !ext_i && per_i > PER_W'(1)) |=> (!tick_o || ext_i || per_i <= PER_W'(1)));
endmodule

// File: rtl/cmp_filter.sv
module cmp_filter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             ext_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic             level_i,
  output logic             cout_o
);
  logic             filt_q;
  logic [CNT_W-1:0] agree_q;
  logic [CNT_W:0]   agree_nxt;
  logic             bypass, zeroed, reached;

  assign bypass    = (cnt_i == '0) && !ext_i;
  assign zeroed    = (cnt_i == '0) && ext_i;
  assign agree_nxt = {1'b0, agree_q} + (CNT_W+1)'(1);
  assign reached   = agree_nxt >= {1'b0, cnt_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q  <= 1'b0;
      agree_q <= '0;
    end else if (!en_i || zeroed) begin
      filt_q  <= 1'b0;
      agree_q <= '0;
    end else if (bypass) begin
      filt_q  <= level_i;
      agree_q <= '0;
    end else if (restart_i) begin
      agree_q <= '0;
    end else if (tick_i) begin
      if (level_i == filt_q) begin
        agree_q <= '0;
      end else if (reached) begin
        filt_q  <= level_i;
        agree_q <= '0;
      end else begin
        agree_q <= agree_nxt[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    if (!en_i || zeroed) cout_o = 1'b0;
    else if (bypass)     cout_o = level_i;
    else                 cout_o = filt_q;
  end

  // R8: between samples the filtered level is held
  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_i != '0 && !tick_i) |=> $stable(filt_q));
  // R6: zero count with external sampling forces a low output
  a_r6_zero_count_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cnt_i == '0 && ext_i) |-> !cout_o);
  // R4: the agreement counter never reaches the programmed count
  a_r4_agree_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_i != '0 && !restart_i) |=> (agree_q < $past(cnt_i) || cnt_i != $past(cnt_i)));
endmodule

// File: rtl/cmp_flags.sv
module cmp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic cout_i,
  input  logic stop_i,
  input  logic stop_edge_i,
  input  logic clr_rise_i,
  input  logic clr_fall_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q, rise_q, fall_q, level_mode, set_rise, set_fall;

  assign level_mode = stop_i && !stop_edge_i;
  assign set_rise = en_i && (level_mode ? cout_i  : (cout_i && !prev_q));
  assign set_fall = en_i && (level_mode ? !cout_i : (!cout_i && prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= cout_i;
      rise_q <= (rise_q && !clr_rise_i) || set_rise;
      fall_q <= (fall_q && !clr_fall_i) || set_fall;
    end
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R10: a rising filtered edge always leaves the rising flag set
  a_r10_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && cout_i && !prev_q) |=> rise_q);
  // R10: a falling filtered edge always leaves the falling flag set
  a_r10_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !cout_i && prev_q) |=> fall_q);
  // R11: in level mode a low output keeps the falling flag set
  a_r11_level_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && stop_i && !stop_edge_i && !cout_i) |=> fall_q);
endmodule

// File: rtl/cmp_cond.sv
module cmp_cond
  import cmp_cond_pkg::*;
#(
  parameter int PER_W       = 8,
  parameter int CNT_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_raw_i,
  input  logic              gate_i,
  input  logic              stop_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              pin_o,
  output logic              irq_o,
  output logic              dma_o
);
  ctrl_t            ctrl_q;
  irqcfg_t          cfg_q;
  logic [PER_W-1:0] per_q;
  logic wr_ctrl, wr_per, wr_stat, restart;
  logic sync_lvl, couta, cout, tick, rise, fall, want;

  assign wr_ctrl = reg_we_i && reg_addr_i == ADDR_CTRL;
  assign wr_per  = reg_we_i && reg_addr_i == ADDR_PER;
  assign wr_stat = reg_we_i && reg_addr_i == ADDR_STAT;
  assign restart = (wr_ctrl && reg_wdata_i[7:5] != ctrl_q.cnt) ||
                   (wr_per  && reg_wdata_i[PER_W-1:0] != per_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      per_q  <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i);
      if (wr_per)  per_q  <= reg_wdata_i[PER_W-1:0];
      if (wr_stat) cfg_q  <= irqcfg_t'(reg_wdata_i[ST_CFG_HI:ST_CFG_LO]);
    end
  end

  cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(cmp_raw_i), .q_o(sync_lvl)
  );

  assign couta = sync_lvl ^ ctrl_q.inv;

  cmp_timer #(.PER_W(PER_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.en), .restart_i(restart),
    .ext_i(ctrl_q.ext), .gate_i(gate_i), .per_i(per_q), .tick_o(tick)
  );

  cmp_filter #(.CNT_W(CNT_W)) filter_i (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_q.en), .ext_i(ctrl_q.ext),
    .cnt_i(CNT_W'(ctrl_q.cnt)), .restart_i(restart), .tick_i(tick),
    .level_i(couta), .cout_o(cout)
  );

  cmp_flags flags_i (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_q.en), .cout_i(cout),
    .stop_i(stop_i), .stop_edge_i(cfg_q.stop_edge),
    .clr_rise_i(wr_stat && reg_wdata_i[ST_RISE]),
    .clr_fall_i(wr_stat && reg_wdata_i[ST_FALL]),
    .rise_o(rise), .fall_o(fall)
  );

  assign want  = ctrl_q.en && ((rise && cfg_q.rise_ie) || (fall && cfg_q.fall_ie));
  assign irq_o = want && !cfg_q.dma_en;
  assign dma_o = want && cfg_q.dma_en;
  assign pin_o = ctrl_q.en && ctrl_q.pin_en && (ctrl_q.raw_sel ? couta : cout);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = ctrl_q;
      ADDR_PER:  reg_rdata_o = 8'(per_q);
      ADDR_STAT: reg_rdata_o = {1'b0, cfg_q, fall, rise, cout};
      default:   reg_rdata_o = '0;
    endcase
  end

  // R12: a request never goes to both destinations
  a_r12_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_o, dma_o}));
  // R13: a disabled block is silent
  a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> (!pin_o && !irq_o && !dma_o));
  // R9: the pin is only high when the pin enable is set
  a_r9_pin_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pin_o |-> ctrl_q.pin_en);
endmodule

// File: tb/cmp_cond_tb_top.sv
module cmp_cond_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0, gate = 1'b0, stop = 1'b0, we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic pin, irq, dma;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_cond dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_raw_i(raw), .gate_i(gate), .stop_i(stop),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_o(pin), .irq_o(irq), .dma_o(dma)
  );

  // {ctrl, init raw, new raw, edges to wait, expected pin}
  localparam int NV = 16;
  localparam logic [14:0] VEC [NV] = '{
    {8'h03, 1'b0, 1'b1, 4'd1, 1'b0},  // R2 one edge: not yet through
    {8'h03, 1'b0, 1'b1, 4'd2, 1'b1},  // R5 bypass after two edges
    {8'h0B, 1'b0, 1'b1, 4'd2, 1'b0},  // R3 inverted
    {8'h0B, 1'b0, 1'b1, 4'd1, 1'b1},  // R3 inverted old level
    {8'h23, 1'b0, 1'b1, 4'd2, 1'b0},  // R4 N=1 early
    {8'h23, 1'b0, 1'b1, 4'd3, 1'b1},  // R4 N=1 first sample
    {8'h63, 1'b0, 1'b1, 4'd4, 1'b0},  // R4 N=3 early
    {8'h63, 1'b0, 1'b1, 4'd5, 1'b1},  // R4 N=3 due
    {8'hE3, 1'b1, 1'b0, 4'd8, 1'b1},  // R4 N=7 early
    {8'hE3, 1'b1, 1'b0, 4'd9, 1'b0},  // R4 N=7 due
    {8'hE7, 1'b0, 1'b1, 4'd2, 1'b1},  // R9 raw select
    {8'hE7, 1'b0, 1'b1, 4'd1, 1'b0},  // R9 raw select early
    {8'hE1, 1'b0, 1'b1, 4'd12, 1'b0}, // R9 pin disabled
    {8'h13, 1'b0, 1'b1, 4'd4, 1'b0},  // R6 zero count, external
    {8'h6B, 1'b1, 1'b0, 4'd4, 1'b0},  // R3 R4 inverted filter early
    {8'h6B, 1'b1, 1'b0, 4'd5, 1'b1}   // R3 R4 inverted filter due
  };
  localparam int VTAG [NV] = '{2, 5, 3, 3, 4, 4, 4, 4, 4, 4, 9, 9, 9, 6, 4, 4};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; raw = 1'b0; gate = 1'b0; stop = 1'b0; we = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);
  endtask

  initial begin
    logic [7:0] r;
    do_reset();
    // R1 reset state
    rd(2'd0, r); check("R1 ctrl", r, 8'h00);
    rd(2'd1, r); check("R1 period", r, 8'h00);
    rd(2'd2, r); check("R1 status", r, 8'h00);
    check("R1 outputs", {5'd0, pin, irq, dma}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      raw = VEC[i][6];
      wr(2'd0, VEC[i][14:7]);
      step(12);
      raw = VEC[i][5];
      step(int'(VEC[i][4:1]));
      check($sformatf("R%0d vector %0d", VTAG[i], i), {7'd0, pin}, {7'd0, VEC[i][0]});
    end

    // R4 glitch shorter than N is rejected
    do_reset();
    wr(2'd0, 8'h63); step(8);
    raw = 1'b1; step(2); raw = 1'b0; step(10);
    check("R4 glitch", {7'd0, pin}, 8'h00);

    // R7 period 4, N=2: change between edge 7 and edge 10
    do_reset();
    wr(2'd0, 8'h43); wr(2'd1, 8'd4);
    rd(2'd1, r); check("R7 period readback", r, 8'd4);
    step(16);
    raw = 1'b1; step(6);
    check("R7 too early", {7'd0, pin}, 8'h00);
    step(4);
    check("R7 due", {7'd0, pin}, 8'h01);

    // R8 external strobe
    do_reset();
    wr(2'd0, 8'h33);
    raw = 1'b1; step(10);
    check("R8 no strobe holds", {7'd0, pin}, 8'h00);
    gate = 1'b1; step(1); gate = 1'b0;
    check("R8 strobe samples", {7'd0, pin}, 8'h01);

    // R14 count change restarts agreement
    do_reset();
    wr(2'd0, 8'h63); step(8);
    raw = 1'b1; step(4);
    wr(2'd0, 8'h83);
    step(3);
    check("R14 restart early", {7'd0, pin}, 8'h00);
    step(1);
    check("R14 restart due", {7'd0, pin}, 8'h01);

    // R10 R12 flags and routing
    do_reset();
    wr(2'd0, 8'h03); wr(2'd2, 8'h08); step(4);
    raw = 1'b1; step(2);
    check("R10 flag not yet", {7'd0, irq}, 8'h00);
    step(1);
    check("R12 irq on rising", {7'd0, irq}, 8'h01);
    raw = 1'b0; step(4);
    rd(2'd2, r); check("R10 both flags", r, 8'h0E);
    wr(2'd2, 8'h0A);
    rd(2'd2, r); check("R10 w1c rising", r, 8'h0C);
    check("R12 irq cleared", {7'd0, irq}, 8'h00);
    raw = 1'b1; step(2);
    wr(2'd2, 8'h0A);
    rd(2'd2, r); check("R10 clear loses to set", r & 8'h02, 8'h02);
    wr(2'd2, 8'h48);
    check("R12 dma route", {6'd0, irq, dma}, 8'h01);

    // R11 stop mode
    wr(2'd2, 8'h0E);
    stop = 1'b1; step(1);
    rd(2'd2, r); check("R11 level rising", r, 8'h0B);
    wr(2'd2, 8'h28);
    wr(2'd2, 8'h2E);
    step(3);
    rd(2'd2, r); check("R11 edge mode in stop", r, 8'h29);
    stop = 1'b0;

    // R13 disable silences outputs
    wr(2'd2, 8'h08);
    raw = 1'b0; step(4); raw = 1'b1; step(4);
    check("R13 irq before", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h06);
    check("R13 disabled", {5'd0, pin, irq, dma}, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule